// File: doc/BRIEF.md
# DMA Bus Master Cycle Sequencer

This block is the bus-master engine that moves words between an on-chip FIFO and local buffer memory. When the FIFO signals that it needs service, the block raises a bus request and waits for the bus grant. With the grant held, it runs one memory cycle per service request. A cycle is built from the phases T1, T2 and T3, plus any number of wait phases TW. In 32-bit mode an upper-address phase TH comes first.

During each cycle the block drives three kinds of signal:
- the active-low address strobe;
- the active-low read or write strobe;
- the address and write data.

It captures read data at the end of a read cycle. The pads themselves sit outside the block. Instead of driving high-impedance levels, the block produces output-enable signals, and a low enable means the matching pin is floating.

A shared auxiliary pin has two roles:
- In 32-bit mode it strobes the fixed upper address half into external latches.
- In 16-bit mode it is a plain port-request output.

Until the configuration is marked as programmed, the auxiliary pin is not driven.

Top module: `dma_cycle_seq`

## Requirements
- R1: `bus_req` is high whenever `svc_req` is high or a cycle is in progress. It falls only once the last requested cycle has completed and `svc_req` is low.
- R2: No cycle starts while `bus_grant` is low: `as_n`, `rd_n` and `wr_n` stay high. `ctl_oe` (enable for strobes and address) equals `bus_grant`, so these pins float without a grant.
- R3: A cycle runs T1, T2, T3 in consecutive clocks. In T1, `as_n` is low and `addr_bus` carries the lower address that was sampled when the cycle started. In 32-bit mode a single TH phase comes before T1.
- R4: In a write cycle (`xfer_wr`=1), `wr_n` is low through T2, T3 and every TW, while `rd_n` stays high. While `wr_n` is low, `data_oe` is 1 and `data_out` equals the write data sampled at cycle start.
- R5: In a read cycle (`xfer_wr`=0), `rd_n` is low through T2, T3 and every TW, while `wr_n` stays high. `data_in` is sampled on the clock edge that ends the cycle. It appears on `rd_data`, with `rd_valid` high, for one clock after that edge.
- R6: `ready` is sampled in T3 and in every TW. Each high sample adds one TW, so the read or write strobe is low for exactly 2+N clocks when `ready` is high for N samples.
- R7: If `svc_req` and `bus_grant` are both high when a cycle ends, the next cycle begins with no idle clock in between.
- R8: In 32-bit mode (`cfg_set`=1, `wide_mode`=1), each TH phase has:
  - `aux_out`=1;
  - `addr_bus` equal to `addr_hi`;
  - `as_n` high.

  In this mode `aux_oe` equals `bus_grant`.
- R9: In 16-bit mode (`cfg_set`=1, `wide_mode`=0), `aux_oe` is always 1. `aux_out` is 1 during every phase of a write cycle and 0 otherwise.
- R10: While `cfg_set` is 0, `aux_oe` is 0 whatever the grant.
- R11: After synchronous reset, the following hold with no grant and no service request: `bus_req`=0, `ctl_oe`=0, `rd_valid`=0, and all strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| svc_req | input | 1 | FIFO needs a transfer |
| xfer_wr | input | 1 | 1 = write to memory, 0 = read from memory |
| addr_lo | input | AW | Lower address for the next cycle |
| addr_hi | input | AW | Fixed upper address half |
| wdata | input | DW | Write data for the next cycle |
| cfg_set | input | 1 | Configuration has been programmed |
| wide_mode | input | 1 | 1 = 32-bit addressing mode |
| bus_grant | input | 1 | Bus granted to this master, active high |
| ready | input | 1 | High requests a wait phase |
| data_in | input | DW | Memory read data |
| bus_req | output | 1 | Bus request, active high |
| ctl_oe | output | 1 | Enable for strobes and address pins |
| as_n | output | 1 | Address strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_bus | output | AW | Address output |
| data_oe | output | 1 | Enable for write data pins |
| data_out | output | DW | Write data output |
| aux_oe | output | 1 | Enable for the shared auxiliary pin |
| aux_out | output | 1 | Upper-address strobe or port request |
| rd_data | output | DW | Captured read data |
| rd_valid | output | 1 | `rd_data` is new this clock |

## Verification
The assertions assume that the grant stays high from the start of a cycle until that cycle ends, and that `ready` holds no meaning outside T3 and TW. The stimulus respects both assumptions: the grant is removed only after a cycle has finished and the block is idle, and `ready` is raised only in the clocks the bench has identified as T3 or TW. Within those limits, the sweeps cover:
- both transfer directions;
- both address modes;
- zero to three wait phases;
- back-to-back runs and held-off grants.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_TH   = 3'd1,
        PH_T1   = 3'd2,
        PH_T2   = 3'd3,
        PH_T3   = 3'd4,
        PH_TW   = 3'd5
    } phase_e;

    typedef struct packed {
        logic wr;
        logic wide;
    } cyc_attr_t;

    function automatic logic in_strobe_phase(input phase_e ph);
        return (ph == PH_T2) || (ph == PH_T3) || (ph == PH_TW);
    endfunction

    function automatic logic in_ready_phase(input phase_e ph);
        return (ph == PH_T3) || (ph == PH_TW);
    endfunction

endpackage

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      svc_req,
    input  logic      bus_grant,
    input  logic      ready,
    input  logic      xfer_wr,
    input  logic      wide_sel,
    output phase_e    phase,
    output cyc_attr_t attr,
    output logic      start,
    output logic      cyc_end,
    output logic      busy
);

    phase_e nxt;

    always_comb begin
        cyc_end = in_ready_phase(phase) && !ready;
        start   = svc_req && bus_grant && ((phase == PH_IDLE) || cyc_end);
        busy    = (phase != PH_IDLE);
        nxt     = phase;
        if (start) begin
            nxt = wide_sel ? PH_TH : PH_T1;
        end else begin
            case (phase)
                PH_TH:        nxt = PH_T1;
                PH_T1:        nxt = PH_T2;
                PH_T2:        nxt = PH_T3;
                PH_T3, PH_TW: nxt = ready ? PH_TW : PH_IDLE;
                default:      nxt = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            attr  <= '0;
        end else begin
            phase <= nxt;
            if (start) begin
                attr.wr   <= xfer_wr;
                attr.wide <= wide_sel;
            end
        end
    end

    // R2: an idle sequencer without grant stays idle
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !bus_grant) |=> (phase == PH_IDLE));

    // R6: a high ready in T3 or TW yields a wait phase
    p_wait_insert_r6: assert property (@(posedge clk) disable iff (rst)
        (in_ready_phase(phase) && ready) |=> (phase == PH_TW));

    // R3: fixed phase order
    p_t1_to_t2_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_T1) |=> (phase == PH_T2));
    p_t2_to_t3_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_T2) |=> (phase == PH_T3));
    p_th_to_t1_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TH) |=> (phase == PH_T1));

endmodule

// File: rtl/dma_seq_dpath.sv
module dma_seq_dpath #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          cyc_end,
    input  logic          cur_wr,
    input  logic [AW-1:0] addr_lo,
    input  logic [AW-1:0] addr_hi,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] data_in,
    output logic [AW-1:0] lat_lo,
    output logic [AW-1:0] lat_hi,
    output logic [DW-1:0] lat_wd,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_lo   <= '0;
            lat_hi   <= '0;
            lat_wd   <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (start) begin
                lat_lo <= addr_lo;
                lat_hi <= addr_hi;
                lat_wd <= wdata;
            end
            rd_valid <= cyc_end && !cur_wr;
            if (cyc_end && !cur_wr) begin
                rd_data <= data_in;
            end
        end
    end

    // R3: the latched address is held while no new cycle starts
    p_addr_held_r3: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(lat_lo));

endmodule

// File: rtl/dma_seq_drv.sv
module dma_seq_drv
    import dma_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  phase_e        phase,
    input  cyc_attr_t     attr,
    input  logic          bus_grant,
    input  logic          cfg_set,
    input  logic          wide_mode,
    input  logic [AW-1:0] lat_lo,
    input  logic [AW-1:0] lat_hi,
    input  logic [DW-1:0] lat_wd,
    output logic          ctl_oe,
    output logic          as_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic [AW-1:0] addr_bus,
    output logic          data_oe,
    output logic [DW-1:0] data_out,
    output logic          aux_oe,
    output logic          aux_out
);

    logic strobe;

    always_comb begin
        strobe   = in_strobe_phase(phase);
        ctl_oe   = bus_grant;
        as_n     = !(phase == PH_T1);
        rd_n     = !(strobe && !attr.wr);
        wr_n     = !(strobe && attr.wr);
        addr_bus = (phase == PH_TH) ? lat_hi : lat_lo;
        data_oe  = bus_grant && strobe && attr.wr;
        data_out = lat_wd;
        if (!cfg_set) begin
            aux_oe  = 1'b0;
            aux_out = 1'b0;
        end else if (wide_mode) begin
            aux_oe  = bus_grant;
            aux_out = (phase == PH_TH);
        end else begin
            aux_oe  = 1'b1;
            aux_out = attr.wr && (phase != PH_IDLE);
        end
    end

endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          svc_req,
    input  logic          xfer_wr,
    input  logic [AW-1:0] addr_lo,
    input  logic [AW-1:0] addr_hi,
    input  logic [DW-1:0] wdata,
    input  logic          cfg_set,
    input  logic          wide_mode,
    input  logic          bus_grant,
    input  logic          ready,
    input  logic [DW-1:0] data_in,
    output logic          bus_req,
    output logic          ctl_oe,
    output logic          as_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic [AW-1:0] addr_bus,
    output logic          data_oe,
    output logic [DW-1:0] data_out,
    output logic          aux_oe,
    output logic          aux_out,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    phase_e        phase;
    cyc_attr_t     attr;
    logic          start;
    logic          cyc_end;
    logic          busy;
    logic [AW-1:0] lat_lo;
    logic [AW-1:0] lat_hi;
    logic [DW-1:0] lat_wd;

    dma_seq_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .svc_req   (svc_req),
        .bus_grant (bus_grant),
        .ready     (ready),
        .xfer_wr   (xfer_wr),
        .wide_sel  (cfg_set && wide_mode),
        .phase     (phase),
        .attr      (attr),
        .start     (start),
        .cyc_end   (cyc_end),
        .busy      (busy)
    );

    dma_seq_dpath #(.AW(AW), .DW(DW)) dpath_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cyc_end  (cyc_end),
        .cur_wr   (attr.wr),
        .addr_lo  (addr_lo),
        .addr_hi  (addr_hi),
        .wdata    (wdata),
        .data_in  (data_in),
        .lat_lo   (lat_lo),
        .lat_hi   (lat_hi),
        .lat_wd   (lat_wd),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    dma_seq_drv #(.AW(AW), .DW(DW)) drv_i (
        .phase     (phase),
        .attr      (attr),
        .bus_grant (bus_grant),
        .cfg_set   (cfg_set),
        .wide_mode (wide_mode),
        .lat_lo    (lat_lo),
        .lat_hi    (lat_hi),
        .lat_wd    (lat_wd),
        .ctl_oe    (ctl_oe),
        .as_n      (as_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .addr_bus  (addr_bus),
        .data_oe   (data_oe),
        .data_out  (data_out),
        .aux_oe    (aux_oe),
        .aux_out   (aux_out)
    );

    assign bus_req = svc_req || busy;

    // R1: the request is up whenever a data strobe is active
    p_req_in_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> bus_req);

    // R4: read and write strobes are never low together
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R5: end of a read strobe is followed by captured data
    p_rd_capture_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_n) |-> rd_valid);

    // R2: no address strobe without the grant
    p_as_needs_grant_r2: assert property (@(posedge clk) disable iff (rst)
        !as_n |-> $past(bus_grant));

endmodule

// File: tb/dma_cycle_seq_tb_top.sv
module dma_cycle_seq_tb_top;

    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          svc_req = 1'b0;
    logic          xfer_wr = 1'b0;
    logic [AW-1:0] addr_lo = '0;
    logic [AW-1:0] addr_hi = '0;
    logic [DW-1:0] wdata = '0;
    logic          cfg_set = 1'b0;
    logic          wide_mode = 1'b0;
    logic          bus_grant = 1'b0;
    logic          ready = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic          bus_req, ctl_oe, as_n, rd_n, wr_n, data_oe, aux_oe, aux_out, rd_valid;
    logic [AW-1:0] addr_bus;
    logic [DW-1:0] data_out, rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dma_cycle_seq #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst(rst), .svc_req(svc_req), .xfer_wr(xfer_wr),
        .addr_lo(addr_lo), .addr_hi(addr_hi), .wdata(wdata),
        .cfg_set(cfg_set), .wide_mode(wide_mode), .bus_grant(bus_grant),
        .ready(ready), .data_in(data_in), .bus_req(bus_req), .ctl_oe(ctl_oe),
        .as_n(as_n), .rd_n(rd_n), .wr_n(wr_n), .addr_bus(addr_bus),
        .data_oe(data_oe), .data_out(data_out), .aux_oe(aux_oe),
        .aux_out(aux_out), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic one_xfer(input bit wr, input bit wide, input int nwait, input int idx);
        logic [AW-1:0] lo, hi;
        logic [DW-1:0] wd, rp;
        lo = AW'(16'h1000 + idx * 37);
        hi = AW'(16'hA000 ^ idx);
        wd = DW'((idx * 16'h0101) ^ 16'h5A5A);
        rp = ~wd;
        @(negedge clk);
        xfer_wr = wr; wide_mode = wide; cfg_set = 1'b1;
        addr_lo = lo; addr_hi = hi; wdata = wd;
        data_in = 16'hDEAD; ready = 1'b0;
        svc_req = 1'b1; bus_grant = 1'b1;
        if (wide) begin
            @(negedge clk);
            svc_req = 1'b0;
            chk("R8 aux strobe in TH", aux_out, 1);
            chk("R8 upper address in TH", addr_bus, hi);
            chk("R8 as_n high in TH", as_n, 1);
            chk("R8 aux_oe granted", aux_oe, 1);
        end
        @(negedge clk);
        svc_req = 1'b0;
        chk("R3 as_n low in T1", as_n, 0);
        chk("R3 lower address in T1", addr_bus, lo);
        chk("R1 bus_req held in cycle", bus_req, 1);
        if (!wide) chk("R9 port request", aux_out, wr);
        for (int k = 1; k <= 2 + nwait; k++) begin
            @(negedge clk);
            if (wr) begin
                chk("R4 wr_n low", wr_n, 0);
                chk("R4 rd_n high", rd_n, 1);
                chk("R4 data_oe", data_oe, 1);
                chk("R4 data_out", data_out, wd);
            end else begin
                chk("R5 rd_n low", rd_n, 0);
                chk("R5 wr_n high", wr_n, 1);
                chk("R5 data_oe off", data_oe, 0);
            end
            if (k >= 2) ready = (k - 2 < nwait);
            if (k == 2 + nwait) data_in = rp;
        end
        @(negedge clk);
        ready = 1'b0;
        chk("R6 strobe released after 2+N", {30'd0, rd_n, wr_n}, 32'd3);
        chk("R5 rd_valid", rd_valid, !wr);
        if (!wr) chk("R5 rd_data", rd_data, rp);
        chk("R1 bus_req dropped", bus_req, 0);
        data_in = 16'hBEEF;
        bus_grant = 1'b0;
        @(negedge clk);
        chk("R2 ctl_oe follows grant", ctl_oe, 0);
        chk(wide ? "R8 aux_oe released" : "R9 aux_oe always on", aux_oe, !wide);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 bus_req", bus_req, 0);
        chk("R11 ctl_oe", ctl_oe, 0);
        chk("R11 rd_valid", rd_valid, 0);
        chk("R11 strobes", {29'd0, as_n, rd_n, wr_n}, 32'd7);
        // R10 unconfigured auxiliary pin
        chk("R10 aux_oe off", aux_oe, 0);
        bus_grant = 1'b1;
        @(negedge clk);
        chk("R10 aux_oe off with grant", aux_oe, 0);
        bus_grant = 1'b0;

        // Sweep direction, mode and wait count (R3..R6, R8, R9)
        for (int wr = 0; wr < 2; wr++)
            for (int wide = 0; wide < 2; wide++)
                for (int nw = 0; nw < 4; nw++)
                    one_xfer(wr[0], wide[0], nw, wr * 8 + wide * 4 + nw);

        // R2: request held off while the grant is low
        @(negedge clk);
        cfg_set = 1'b1; wide_mode = 1'b0; xfer_wr = 1'b0;
        svc_req = 1'b1; bus_grant = 1'b0; ready = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1 bus_req without grant", bus_req, 1);
            chk("R2 ctl_oe low", ctl_oe, 0);
            chk("R2 no cycle without grant", {30'd0, as_n, rd_n}, 32'd3);
        end
        bus_grant = 1'b1;
        @(negedge clk);
        svc_req = 1'b0;
        chk("R2 cycle starts on grant", as_n, 0);
        repeat (3) @(negedge clk);
        chk("R2 idle again", bus_req, 0);

        // R7: back-to-back writes with svc_req held
        xfer_wr = 1'b1; addr_lo = 16'h4000; svc_req = 1'b1; ready = 1'b0;
        for (int n = 0; n < 9; n++) begin
            @(negedge clk);
            chk("R7 as_n pattern", as_n, (n % 3) != 0);
            chk("R7 bus_req stays", bus_req, 1);
            chk("R7 wr_n pattern", wr_n, (n % 3) == 0);
            if (n % 3 == 0) begin
                chk("R7 address per cycle", addr_bus, AW'(16'h4000 + n / 3));
                addr_lo = AW'(16'h4000 + n / 3 + 1);
            end
            if (n == 6) svc_req = 1'b0;
        end
        @(negedge clk);
        chk("R7 request drops after last", bus_req, 0);
        chk("R7 idle after last", as_n, 1);
        bus_grant = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule